// File: doc/BRIEF.md
# Dual Programmable Down-Counter Timer

This block holds two identical timers that count down. Each timer has its own small register bank. The banks sit 0x20 bytes apart in one address window. A timer decrements on a clock-enable tick that comes from an external reference. A prescaler can slow that tick by 16 or by 256. When the count reaches zero, the timer sets a raw interrupt flag. Each flag can be gated by a per-timer enable. The gated flags of both timers are combined onto one interrupt line.

At zero, a timer behaves according to its mode. In periodic mode it restarts from a programmed reload value. In free-running mode it wraps to the largest value of its width. In one-shot mode it stays at zero. The counter is either 16 or 32 bits wide. Software programs the timers over a simple single-cycle register bus, with registered read data. It can set the reload value in two ways:
- a direct load, which restarts the count immediately;
- a background load, which only changes the value used at the next restart.

Top module: `twin_down_timer`

## Requirements
- R1: After reset each timer's control word reads 0x20 (interrupt enable set, timer stopped, 16-bit, divide by 1, free-running). Its value word reads 0x0000FFFF, because the counter holds all ones and is shown masked to 16 bits. Its raw and masked flags read 0, and `irq_o` is 0.
- R2: Register words per timer (byte offset within the bank):
  - load at 0x00, read/write;
  - current value at 0x04, read;
  - control at 0x08;
  - interrupt clear at 0x0C, write;
  - raw flag at 0x10, bit 0;
  - masked flag at 0x14, bit 0;
  - background load at 0x18.

  A write to 0x00 replaces the counter at once, and the next read of 0x04 returns the written value masked to the current width. A stopped timer (control bit 7 = 0) never changes its count on ticks.
- R3: The count steps by one only when control bit 7 is 1 and a prescaled tick occurs. Control bits 3:2 choose how many reference ticks make one step: 00 gives 1 tick per step, 01 gives 16, and 10 or 11 gives 256. The prescaler restarts from zero while the timer is stopped.
- R4: Periodic mode is control bit 6 = 1 with bit 0 = 0. On the step after the count has reached zero, the counter reloads the load value, masked to the width.
- R5: Free-running mode is bit 6 = 0 with bit 0 = 0. On the step after zero, the counter wraps to 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode.
- R6: One-shot mode is control bit 0 = 1, whatever bit 6 holds. A counter at zero stays at zero, and no further flag is raised until the timer is loaded again.
- R7: Control bit 1 selects the width: 0 for 16 bits, 1 for 32 bits. In 16-bit mode only the low 16 bits count, and the zero test uses only those bits.
- R8: The raw flag sets on the step that takes the count from 1 to 0. Any write to offset 0x0C clears it. If a set and a clear happen in the same cycle, the set wins.
- R9: The masked flag equals the raw flag AND control bit 5. `irq_o` is the OR of both timers' masked flags and follows them one cycle later.
- R10: A write to 0x18 changes the reload value but leaves the running count alone. Reads of 0x00 and 0x18 both return the reload value.
- R11: The second timer answers at 0x20 plus the same offsets. It counts on its own tick input without disturbing the first timer, and its flag also drives `irq_o`.
- R12: Read data appears on `rdata_o` in the cycle after `rd_en_i`. The unused offset 0x1C reads 0. Control bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | NUM_TIMERS | Per-timer reference clock-enable tick |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address; upper bits select the timer, bits 4:2 the word |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The hardest situation to reach from the ports is an interrupt-clear write landing in exactly the cycle that the count steps from one to zero. The bench sets this up by loading one with divide-by-1 selected, then driving the tick and the clear write on the same falling edge. The deep prescaler boundaries are also hard to reach. For these, the bench sweeps every mode, width and divider with tick bursts of the divider times six plus one less than the divider. This leaves the prescaler one tick short of the next step, so an off-by-one count shows up in the value read back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W        = 8;
  localparam int CTL_ONESHOT  = 0;
  localparam int CTL_WIDE     = 1;
  localparam int CTL_PRE_LO   = 2;
  localparam int CTL_PRE_HI   = 3;
  localparam int CTL_IE       = 5;
  localparam int CTL_PERIODIC = 6;
  localparam int CTL_EN       = 7;
  localparam logic [CTL_W-1:0] CTL_RESET = 8'h20;
  localparam logic [CTL_W-1:0] CTL_WMASK = 8'hEF;

  localparam logic [2:0] W_LOAD   = 3'd0;
  localparam logic [2:0] W_VALUE  = 3'd1;
  localparam logic [2:0] W_CTRL   = 3'd2;
  localparam logic [2:0] W_ICLR   = 3'd3;
  localparam logic [2:0] W_RAW    = 3'd4;
  localparam logic [2:0] W_MASKED = 3'd5;
  localparam logic [2:0] W_BGLOAD = 3'd6;

  typedef enum logic [1:0] {MODE_FREE, MODE_PERIODIC, MODE_ONESHOT} run_mode_e;

  function automatic run_mode_e decode_mode(input logic [CTL_W-1:0] c);
    if (c[CTL_ONESHOT])       return MODE_ONESHOT;
    else if (c[CTL_PERIODIC]) return MODE_PERIODIC;
    else                      return MODE_FREE;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int LOG_A = 4,
  parameter int LOG_B = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  logic [LOG_B-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (tick_i)   cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    case (sel_i)
      2'b00:   step_o = run_i && tick_i;
      2'b01:   step_o = run_i && tick_i && (&cnt_q[LOG_A-1:0]);
      default: step_o = run_i && tick_i && (&cnt_q);
    endcase
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LOG_A  = 4,
  parameter int LOG_B  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [2:0]        word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic [DATA_W-1:0] value_o,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic              raw_o,
  output logic              masked_o
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] NARROW = {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}};
  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q, cnt_d, load_q, wmask, cur;
  logic [CTL_W-1:0]  ctrl_q;
  logic              raw_q, step, hit;
  logic              load_wr, bg_wr, ctrl_wr, clr_wr;
  run_mode_e         mode;

  assign load_wr = wr_i && (word_i == W_LOAD);
  assign bg_wr   = wr_i && (word_i == W_BGLOAD);
  assign ctrl_wr = wr_i && (word_i == W_CTRL);
  assign clr_wr  = wr_i && (word_i == W_ICLR);

  assign wmask = ctrl_q[CTL_WIDE] ? '1 : NARROW;
  assign cur   = cnt_q & wmask;
  assign mode  = decode_mode(ctrl_q);

  tmr_prescaler #(.LOG_A(LOG_A), .LOG_B(LOG_B)) pre_i (
    .clk   (clk),
    .rst   (rst),
    .run_i (ctrl_q[CTL_EN]),
    .tick_i(tick_i),
    .sel_i (ctrl_q[CTL_PRE_HI:CTL_PRE_LO]),
    .step_o(step)
  );

  always_comb begin
    cnt_d = cnt_q;
    if (load_wr) begin
      cnt_d = wdata_i;
    end else if (step) begin
      if (cur == '0) begin
        case (mode)
          MODE_PERIODIC: cnt_d = load_q & wmask;
          MODE_FREE:     cnt_d = wmask;
          default:       cnt_d = cur;
        endcase
      end else begin
        cnt_d = cur - ONE;
      end
    end
  end

  assign hit = step && !load_wr && (cur == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;
      load_q <= '0;
      ctrl_q <= CTL_RESET;
      raw_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (load_wr || bg_wr) load_q <= wdata_i;
      if (ctrl_wr) ctrl_q <= wdata_i[CTL_W-1:0] & CTL_WMASK;
      if (hit)         raw_q <= 1'b1;
      else if (clr_wr) raw_q <= 1'b0;
    end
  end

  assign value_o  = cur;
  assign ctrl_o   = ctrl_q;
  assign raw_o    = raw_q;
  assign masked_o = raw_q && ctrl_q[CTL_IE];

  always_comb begin
    case (word_i)
      W_LOAD, W_BGLOAD: rd_word_o = load_q;
      W_VALUE:          rd_word_o = cur;
      W_CTRL:           rd_word_o = DATA_W'(ctrl_q);
      W_RAW:            rd_word_o = DATA_W'(raw_q);
      W_MASKED:         rd_word_o = DATA_W'(masked_o);
      default:          rd_word_o = '0;
    endcase
  end
endmodule

// File: rtl/twin_down_timer.sv
module twin_down_timer
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int LOG_A      = 4,
  parameter int LOG_B      = 8,
  localparam int SEL_W     = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W    = 5 + SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_TIMERS-1:0] tick_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  irq_o
);
  logic [SEL_W-1:0] sel;
  logic [2:0]       word;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] rd_words, val_vec;
  logic [NUM_TIMERS-1:0] raw_vec, masked_vec, ie_vec, en_vec, oneshot_vec;
  logic [DATA_W-1:0] rdata_d;

  assign sel  = addr_i[ADDR_W-1:5];
  assign word = addr_i[4:2];

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    logic [CTL_W-1:0] ctrl;
    tmr_channel #(.DATA_W(DATA_W), .LOG_A(LOG_A), .LOG_B(LOG_B)) ch_i (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick_i[g]),
      .wr_i     (wr_en_i && (sel == SEL_W'(g))),
      .word_i   (word),
      .wdata_i  (wdata_i),
      .rd_word_o(rd_words[g]),
      .value_o  (val_vec[g]),
      .ctrl_o   (ctrl),
      .raw_o    (raw_vec[g]),
      .masked_o (masked_vec[g])
    );
    assign ie_vec[g]      = ctrl[CTL_IE];
    assign en_vec[g]      = ctrl[CTL_EN];
    assign oneshot_vec[g] = ctrl[CTL_ONESHOT];
  end

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_TIMERS; i++)
      if (sel == SEL_W'(i)) rdata_d = rd_words[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rdata_d;
      irq_o <= |masked_vec;
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_TIMERS-1:0] tick_i,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic                  irq_o,
  input logic [NUM_TIMERS-1:0] raw_vec,
  input logic [NUM_TIMERS-1:0] ie_vec,
  input logic [NUM_TIMERS-1:0] en_vec,
  input logic [NUM_TIMERS-1:0] oneshot_vec,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0] val_vec
);
  localparam int SEL_W = ADDR_W - 5;

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(raw_vec & ie_vec))); // R9

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
    logic       here;
    logic [2:0] wd;
    assign here = wr_en_i && (addr_i[ADDR_W-1:5] == SEL_W'(g));
    assign wd   = addr_i[4:2];

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!en_vec[g] && !here) |=> $stable(val_vec[g])); // R2

    AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (rst)
      (!tick_i[g] && !here) |=> $stable(val_vec[g])); // R3

    AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (rst)
      (en_vec[g] && oneshot_vec[g] && val_vec[g] == '0 && !here) |=> (val_vec[g] == '0)); // R6

    AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
      (here && wd == W_ICLR && !tick_i[g]) |=> !raw_vec[g]); // R8

    AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      $rose(raw_vec[g]) |-> (val_vec[g] == '0)); // R8
  end
endmodule

bind twin_down_timer tmr_checker #(
  .NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .irq_o      (irq_o),
  .raw_vec    (raw_vec),
  .ie_vec     (ie_vec),
  .en_vec     (en_vec),
  .oneshot_vec(oneshot_vec),
  .val_vec    (val_vec)
);

// File: tb/twin_down_timer_tb_top.sv
module twin_down_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  tick = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twin_down_timer dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick[idx] = 1'b1;
    end
    @(negedge clk); tick[idx] = 1'b0;
  endtask

  // mode: 0 free-running, 1 periodic, 2 one-shot
  function automatic logic [31:0] model(input int mode, input bit wide,
                                        input logic [31:0] ld, input int steps,
                                        output bit raw);
    logic [31:0] m, v;
    m = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    v = ld & m; raw = 0;
    for (int s = 0; s < steps; s++) begin
      if (v == 0) begin
        if (mode == 1) v = ld & m;
        else if (mode == 0) v = m;
      end else begin
        v = v - 1;
        if (v == 0) raw = 1;
      end
    end
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ev;
    bit er;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(6'h08, d); chk("R1 ctrl0", d, 32'h20);
    rd(6'h28, d); chk("R1 ctrl1", d, 32'h20);
    rd(6'h04, d); chk("R1 value0", d, 32'h0000FFFF);
    rd(6'h10, d); chk("R1 raw0", d, 0);
    rd(6'h14, d); chk("R1 masked0", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R12 unused offset and reserved control bit
    rd(6'h1C, d); chk("R12 unused", d, 0);
    wr(6'h08, 32'h0000_0017);
    rd(6'h08, d); chk("R12 bit4", d, 32'h07);
    wr(6'h08, 32'h0);

    // R2 stopped timer ignores ticks
    wr(6'h00, 32'd5);
    rd(6'h04, d); chk("R2 load", d, 5);
    ticks(0, 3);
    rd(6'h04, d); chk("R2 stopped", d, 5);

    // R3-R7 sweep: mode x width x prescale
    for (int mode = 0; mode < 3; mode++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 3; p++) begin
          int dv;
          logic [31:0] cfg;
          dv  = (p == 0) ? 1 : (p == 1) ? 16 : 256;
          cfg = 32'hA0 | (p << 2) | (w << 1) | (mode == 2 ? 1 : 0) | (mode == 1 ? 32'h40 : 0);
          wr(6'h08, 32'h0);
          wr(6'h0C, 32'h0);
          wr(6'h00, 32'h0001_0003);
          wr(6'h08, cfg);
          ticks(0, dv * 6 + dv - 1);
          ev = model(mode, w[0], 32'h0001_0003, 6, er);
          rd(6'h04, d);
          chk($sformatf("R3 R4 R5 R6 R7 value m%0d w%0d p%0d", mode, w, p), d, ev);
          rd(6'h10, d); chk("R8 raw set", d, {31'b0, er});
          rd(6'h14, d); chk("R9 masked", d, {31'b0, er});
          chk("R9 irq", {31'b0, irq}, {31'b0, er});
          wr(6'h0C, 32'hDEAD);
          rd(6'h10, d); chk("R8 raw cleared", d, 0);
        end

    // R9 interrupt enable off hides flag
    wr(6'h08, 32'h0);
    wr(6'h00, 32'd1);
    wr(6'h08, 32'hC2);
    ticks(0, 1);
    rd(6'h10, d); chk("R9 raw ie0", d, 1);
    rd(6'h14, d); chk("R9 masked ie0", d, 0);
    chk("R9 irq ie0", {31'b0, irq}, 0);
    wr(6'h0C, 32'h0);

    // R10 background load
    wr(6'h08, 32'h0);
    wr(6'h00, 32'd4);
    wr(6'h08, 32'hE2);
    ticks(0, 2);
    wr(6'h18, 32'd9);
    rd(6'h04, d); chk("R10 count kept", d, 2);
    rd(6'h00, d); chk("R10 load reads new", d, 9);
    rd(6'h18, d); chk("R10 bg reads new", d, 9);
    ticks(0, 3);
    rd(6'h04, d); chk("R10 reload used", d, 9);

    // R8 set wins over clear in same cycle
    wr(6'h08, 32'h0);
    wr(6'h0C, 32'h0);
    wr(6'h00, 32'd1);
    wr(6'h08, 32'hE2);
    @(negedge clk); tick[0] = 1'b1; wr_en = 1'b1; addr = 6'h0C;
    @(negedge clk); tick[0] = 1'b0; wr_en = 1'b0;
    rd(6'h10, d); chk("R8 set wins", d, 1);
    wr(6'h0C, 32'h0);
    wr(6'h08, 32'h0);

    // R11 second timer independent
    wr(6'h00, 32'd50);
    wr(6'h20, 32'd7);
    wr(6'h28, 32'hE2);
    ticks(1, 3);
    rd(6'h24, d); chk("R11 t1 value", d, 4);
    rd(6'h04, d); chk("R11 t0 untouched", d, 50);
    ticks(1, 4);
    rd(6'h30, d); chk("R11 t1 raw", d, 1);
    rd(6'h10, d); chk("R11 t0 raw", d, 0);
    chk("R11 irq from t1", {31'b0, irq}, 1);
    wr(6'h2C, 32'h0);
    @(negedge clk);
    chk("R11 irq cleared", {31'b0, irq}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule